// File: doc/BRIEF.md
# Presettable Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that can be preset from a parallel word. It produces an active-low terminal-count flag whenever every count bit is one. That flag is the output for chaining stages: a lower stage's flag, inverted, drives the count enable of the next stage up.

With the reload-mode input high, the terminal-count condition is fed back inside the block. On the edge that would normally wrap the count, the counter loads the preset word instead, so it divides the clock by 256 minus the preset. Reload mode must be tied to 0 when it is not used. A complementary pair of registered divider outputs is provided for single-stage divider use. That pair is not meant for cascading.

An asynchronous master reset overrides every other input.

Top module: `tc_reload_counter`

## Requirements
- R1: While `mrst` is high, `count` is 0, `tc_n` is 1, `div_out` is 0 and `div_out_n` is 1, without waiting for a clock edge, whatever the other inputs are.
- R2: `tc_n` is 0 exactly when every bit of `count` is 1, in the same cycle as that count.
- R3: With `load` low and `cnt_en` high, and no reload due, each rising clock edge adds one to `count`.
- R4: With `load` high, the next edge sets `count` to `preset`, whether `cnt_en` is high or low.
- R5: With `load` and `cnt_en` both low, `count` holds its value, even at all-ones with `reload_mode` high.
- R6: With `reload_mode` low and `cnt_en` high, a count of all-ones becomes 0 on the next edge.
- R7: With `reload_mode` high, `cnt_en` high and `tc_n` low, the next edge sets `count` to `preset` instead of wrapping.
- R8: In reload mode with a steady enable and preset P, `count` repeats with a period of 256 − P clocks.
- R9: `div_out` is a registered copy of the all-ones condition: on each edge it takes 1 if `count` was all-ones before that edge. `div_out_n` is always its complement.
- R10: When a second stage's `cnt_en` is driven from the inverted `tc_n` of a first stage that counts every clock, the two counts form one binary count of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mrst | input | 1 | Asynchronous master reset, active high |
| cnt_en | input | 1 | Count enable |
| load | input | 1 | Parallel-load request, takes priority over counting |
| preset | input | WIDTH | Word loaded by `load` or by a terminal-count reload |
| reload_mode | input | 1 | 1 = reload the preset at terminal count; tie to 0 if unused |
| count | output | WIDTH | Present count |
| tc_n | output | 1 | Terminal count, active low; the output for cascading |
| div_out | output | 1 | Registered divider output |
| div_out_n | output | 1 | Complement of `div_out` |

## Verification
The results of `load`, `cnt_en` and `reload_mode` appear on `count` one rising edge after they are applied. `tc_n` follows `count` in the same cycle. `div_out` and `div_out_n` reflect the count from before the same edge, so they lag the all-ones count by one cycle. Reset acts on every output at once, with no edge needed.

The bench changes its inputs on the falling edge and samples all outputs on the next falling edge, so each sample falls after exactly one rising edge. It predicts the divider outputs from the count it expected for the previous step. The period and cascade tests count edges in the bench and compare against the value calculated from the preset or from the number of clocks applied.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_INC  = 2'd1,
      OP_LOAD = 2'd2
   } tcr_op_e;
endpackage

// File: rtl/tcr_term.sv
module tcr_term #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] count,
   output logic             all_ones
);
   logic [WIDTH-1:0] chain;

   assign chain[0] = count[0];
   for (genvar i = 1; i < WIDTH; i++) begin : g_and
      assign chain[i] = chain[i-1] & count[i];
   end

   assign all_ones = chain[WIDTH-1];
endmodule

// File: rtl/tcr_ctl.sv
module tcr_ctl
   import tcr_pkg::*;
(
   input  logic    load,
   input  logic    cnt_en,
   input  logic    reload_mode,
   input  logic    all_ones,
   output tcr_op_e op
);
   always_comb begin
      if (load)                             op = OP_LOAD;
      else if (!cnt_en)                     op = OP_HOLD;
      else if (reload_mode && all_ones)     op = OP_LOAD;
      else                                  op = OP_INC;
   end
endmodule

// File: rtl/tcr_divout.sv
module tcr_divout #(
   parameter bit DUAL_FF = 1'b1
) (
   input  logic clk,
   input  logic mrst,
   input  logic term,
   output logic q,
   output logic q_n
);
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) q <= 1'b0;
      else      q <= term;
   end

   if (DUAL_FF) begin : g_dual
      always_ff @(posedge clk or posedge mrst) begin
         if (mrst) q_n <= 1'b1;
         else      q_n <= ~term;
      end
   end else begin : g_single
      assign q_n = ~q;
   end
endmodule

// File: rtl/tc_reload_counter.sv
module tc_reload_counter
   import tcr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit DIV_DUAL_FF = 1'b1
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             cnt_en,
   input  logic             load,
   input  logic [WIDTH-1:0] preset,
   input  logic             reload_mode,
   output logic [WIDTH-1:0] count,
   output logic             tc_n,
   output logic             div_out,
   output logic             div_out_n
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad_width
      $error("tc_reload_counter: WIDTH must be at least 2");
   end

   logic             all_ones;
   tcr_op_e          op;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   tcr_term #(.WIDTH(WIDTH)) u_term (
      .count    (cnt_q),
      .all_ones (all_ones)
   );

   tcr_ctl u_ctl (
      .load        (load),
      .cnt_en      (cnt_en),
      .reload_mode (reload_mode),
      .all_ones    (all_ones),
      .op          (op)
   );

   always_comb begin
      unique case (op)
         OP_LOAD: cnt_d = preset;
         OP_INC:  cnt_d = cnt_q + ONE;
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) cnt_q <= '0;
      else      cnt_q <= cnt_d;
   end

   tcr_divout #(.DUAL_FF(DIV_DUAL_FF)) u_div (
      .clk  (clk),
      .mrst (mrst),
      .term (all_ones),
      .q    (div_out),
      .q_n  (div_out_n)
   );

   assign count = cnt_q;
   assign tc_n  = ~all_ones;
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             mrst,
   input logic             cnt_en,
   input logic             load,
   input logic [WIDTH-1:0] preset,
   input logic             reload_mode,
   input logic [WIDTH-1:0] count,
   input logic             tc_n,
   input logic             div_out,
   input logic             div_out_n
);
   localparam logic [WIDTH-1:0] ONES = '1;

   // R1: outputs at reset values while reset is held
   always @(negedge clk) begin
      if (mrst) begin
         p_reset_vals_r1: assert (count == '0 && tc_n && !div_out && div_out_n)
            else $error("reset values wrong");
      end
   end

   p_tc_ones_r2: assert property (@(posedge clk) disable iff (mrst)
      (tc_n == 1'b0) == (count == ONES));

   p_inc_r3: assert property (@(posedge clk) disable iff (mrst)
      (!load && cnt_en && count != ONES) |=> count == $past(count) + WIDTH'(1));

   p_load_r4: assert property (@(posedge clk) disable iff (mrst)
      load |=> count == $past(preset));

   p_hold_r5: assert property (@(posedge clk) disable iff (mrst)
      (!load && !cnt_en) |=> $stable(count));

   p_wrap_r6: assert property (@(posedge clk) disable iff (mrst)
      (!load && cnt_en && !reload_mode && !tc_n) |=> count == '0);

   p_reload_r7: assert property (@(posedge clk) disable iff (mrst)
      (!load && cnt_en && reload_mode && !tc_n) |=> count == $past(preset));

   p_div_copy_r9: assert property (@(posedge clk) disable iff (mrst)
      1'b1 |=> div_out == ($past(count) == ONES));

   p_div_compl_r9: assert property (@(posedge clk) disable iff (mrst)
      div_out_n == !div_out);
endmodule

bind tc_reload_counter tcr_checker #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .mrst        (mrst),
   .cnt_en      (cnt_en),
   .load        (load),
   .preset      (preset),
   .reload_mode (reload_mode),
   .count       (count),
   .tc_n        (tc_n),
   .div_out     (div_out),
   .div_out_n   (div_out_n)
);

// File: tb/tc_reload_counter_tb.sv
module tc_reload_counter_tb;
   logic       clk = 1'b0;
   logic       mrst;
   logic       cnt_en, load, reload_mode;
   logic [7:0] preset;
   logic [7:0] count;
   logic       tc_n, div_out, div_out_n;
   int         checks = 0;
   int         failures = 0;
   logic       done = 1'b0;

   always #10 clk = ~clk;

   tc_reload_counter #(.WIDTH(8)) u_dut (
      .clk(clk), .mrst(mrst), .cnt_en(cnt_en), .load(load), .preset(preset),
      .reload_mode(reload_mode), .count(count), .tc_n(tc_n),
      .div_out(div_out), .div_out_n(div_out_n)
   );

   // cascade pair for R10
   logic       casc_en;
   logic [7:0] lo_q, hi_q;
   logic       lo_tc_n, hi_tc_n, lo_d, lo_dn, hi_d, hi_dn;

   tc_reload_counter #(.WIDTH(8)) u_casc_lo (
      .clk(clk), .mrst(mrst), .cnt_en(casc_en), .load(1'b0), .preset(8'h00),
      .reload_mode(1'b0), .count(lo_q), .tc_n(lo_tc_n),
      .div_out(lo_d), .div_out_n(lo_dn)
   );
   tc_reload_counter #(.WIDTH(8)) u_casc_hi (
      .clk(clk), .mrst(mrst), .cnt_en(casc_en & ~lo_tc_n), .load(1'b0), .preset(8'h00),
      .reload_mode(1'b0), .count(hi_q), .tc_n(hi_tc_n),
      .div_out(hi_d), .div_out_n(hi_dn)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {load, cnt_en, reload_mode, preset[7:0], expected count[7:0]}
   localparam int NV = 14;
   localparam logic [18:0] VEC [NV] = '{
      {3'b100, 8'hFD, 8'hFD},   // R4 load
      {3'b010, 8'h00, 8'hFE},   // R3
      {3'b010, 8'h00, 8'hFF},   // R3
      {3'b010, 8'h55, 8'h00},   // R6 wrap
      {3'b100, 8'hF0, 8'hF0},   // R4 load with enable low
      {3'b000, 8'h33, 8'hF0},   // R5 hold
      {3'b110, 8'h10, 8'h10},   // R4 load over count
      {3'b100, 8'hFE, 8'hFE},   // R4
      {3'b011, 8'h40, 8'hFF},   // R3 in reload mode
      {3'b011, 8'h40, 8'h40},   // R7 reload
      {3'b011, 8'h40, 8'h41},   // R3
      {3'b001, 8'h99, 8'h41},   // R5 hold in reload mode
      {3'b101, 8'hFF, 8'hFF},   // R4 load all-ones
      {3'b001, 8'h20, 8'hFF}    // R5 hold at all-ones, no reload
   };

   initial begin
      logic [7:0] prev;
      int         last_hit, period, div_hits;
      mrst = 1'b1; cnt_en = 1'b0; load = 1'b0; reload_mode = 1'b0;
      preset = 8'h00; casc_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 count", count, 0);
      chk("R1 tc_n", tc_n, 1);
      chk("R1 div_out", div_out, 0);
      chk("R1 div_out_n", div_out_n, 1);
      mrst = 1'b0;
      @(negedge clk);
      chk("R5 idle", count, 0);

      prev = 8'h00;
      for (int i = 0; i < NV; i++) begin
         {load, cnt_en, reload_mode, preset} = VEC[i][18:8];
         @(negedge clk);
         chk("R3-R7 vector count", count, VEC[i][7:0]);
         chk("R2 tc_n", tc_n, (VEC[i][7:0] == 8'hFF) ? 0 : 1);
         chk("R9 div_out", div_out, (prev == 8'hFF) ? 1 : 0);
         chk("R9 div_out_n", div_out_n, (prev == 8'hFF) ? 0 : 1);
         prev = VEC[i][7:0];
      end

      // R8: reload period 256 - P with P = F6
      load = 1'b1; cnt_en = 1'b1; reload_mode = 1'b1; preset = 8'hF6;
      @(negedge clk);
      load = 1'b0;
      last_hit = 0; period = 0; div_hits = 0;
      for (int c = 1; c <= 35; c++) begin
         @(negedge clk);
         if (div_out) div_hits++;
         if (div_out_n == div_out) chk("R9 complement", div_out_n, !div_out);
         if (count == 8'hF6) begin
            if (last_hit != 0 && period == 0) period = c - last_hit;
            last_hit = c;
         end
      end
      chk("R8 period", period, 10);
      chk("R9 div pulses in 35 clocks", div_hits, 3);

      // R1: asynchronous reset with no clock edge
      @(negedge clk);
      #3 mrst = 1'b1;
      #2;
      chk("R1 async count", count, 0);
      chk("R1 async tc_n", tc_n, 1);
      chk("R1 async div_out_n", div_out_n, 1);
      @(negedge clk);
      load = 1'b1; preset = 8'h77;
      @(negedge clk);
      chk("R1 reset overrides load", count, 0);
      load = 1'b0; cnt_en = 1'b0; reload_mode = 1'b0;
      mrst = 1'b0;

      // R10: cascade of two stages
      @(negedge clk);
      casc_en = 1'b1;
      repeat (700) @(negedge clk);
      casc_en = 1'b0;
      chk("R10 cascade count", {hi_q, lo_q}, 700);
      @(negedge clk);
      chk("R10 cascade hold", {hi_q, lo_q}, 700);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule